// File: doc/BRIEF.md
# Gain-Ranging Attenuation Step Controller

This block is the digital decision logic that steers a stepped input attenuator ahead of a gain-ranging converter. On every encode clock it takes one signed sample, forms its magnitude so that positive and negative peaks count equally, and compares it against a ladder of trip levels. The trip levels are set a factor of two apart, starting at half of full scale. The result is a 3-bit attenuation code that picks 0 to 30 dB of attenuation, in 6 dB steps, for the following conversion.

The trip flags are captured once per encode cycle and cleared again for the next one. The code register then acts on them. Attenuation is added at once when the peak reaches a higher step's trip level. The levels sit one step below where the converter would overrange, which gives 6 dB of spare headroom until the largest step is in use. A step is released only when the peak falls a further 6 dB below the trip level of the current step. A single quiet sample flushes any amount of attenuation.

Top module: `gr_atten_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) forces `att_code` to 0 and clears every captured trip flag. With `rst` held, no sample changes `att_code`.
- R2: With full scale FS = 2^(SAMPLE_W-1), the attack levels are FS/2, FS/4, FS/8, FS/16 and FS/32. A magnitude equal to a level counts as reaching it. The step count n is the number of attack levels reached, from 0 to 5.
- R3: The magnitude of a negative sample is its negation, so -v and +v yield the same code. The most negative sample, -FS, counts as magnitude FS.
- R4: A sample present before rising edge k is captured at edge k. The code it selects appears on `att_code` after edge k+1, and stays unchanged after edge k.
- R5: When n is greater than the current code c, the code becomes n at the next update, jumping over intermediate steps. This holds both from 0 and from any lower step.
- R6: When n ≤ c, c > 0 and the magnitude is at least FS >> (7-c) (one level below the one that selects c), the code stays c.
- R7: When n < c and the magnitude is below FS >> (7-c), the code drops straight to n in a single update. One quiet sample therefore removes all attenuation.
- R8: The code saturates at 5 (30 dB) for any magnitude up to and including FS. The values 6 and 7 never appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Encode clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sample | input | SAMPLE_W | Signed two's-complement input sample |
| att_code | output | 3 | Attenuation step for the next conversion, 0 = none, each step 6 dB |

## Verification
A sample takes two rising edges to reach `att_code`: one to capture the trip flags and one to update the code. The code update with an unchanged sample settles to the same value, so each table row holds its sample across three edges and reads the code at the following falling edge. The directed tests look at the code after exactly one and after exactly two edges. They confirm that nothing moves early (R4), that a one-sample burst is flushed by one quiet sample, and that reset takes effect at the first edge.

// File: rtl/gr_pkg.sv
package gr_pkg;

  // Magnitude of a sign-extended sample; both polarities map to a positive value.
  function automatic logic [31:0] gr_abs(input logic signed [31:0] v);
    return (v < 0) ? 32'(-v) : 32'(v);
  endfunction

  // Step update: rise at once, hold inside the hysteresis band, else drop to target.
  function automatic logic [7:0] gr_next_code(input logic [7:0] cur,
                                              input logic [7:0] tgt,
                                              input logic       hold);
    if (tgt > cur) return tgt;
    if (hold)      return cur;
    return tgt;
  endfunction

endpackage

// File: rtl/gr_peak_latch.sv
module gr_peak_latch #(
  parameter int SAMPLE_W = 12,
  parameter int LEVELS   = 6
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic signed [SAMPLE_W-1:0] sample,
  output logic [LEVELS-1:0]          peak_q
);
  import gr_pkg::*;

  localparam logic [31:0] FULL_SCALE = 32'd1 << (SAMPLE_W - 1);

  logic signed [31:0] s_ext;
  logic [31:0]        mag;
  logic [LEVELS-1:0]  trip;

  assign s_ext = {{(32 - SAMPLE_W){sample[SAMPLE_W-1]}}, sample};
  assign mag   = gr_abs(s_ext);

  // Bit j trips at FULL_SCALE >> (j+1): bit 0 is the highest level.
  for (genvar j = 0; j < LEVELS; j++) begin : g_cmp
    assign trip[j] = (mag >= (FULL_SCALE >> (j + 1)));
  end

  // Flags live for one encode period and are replaced on the next edge.
  always_ff @(posedge clk) begin
    if (rst) peak_q <= '0;
    else     peak_q <= trip;
  end

endmodule

// File: rtl/gr_level_encode.sv
module gr_level_encode #(
  parameter int N_STEPS = 5,
  parameter int CODE_W  = 3
) (
  input  logic [N_STEPS:0]  peak_flags,
  input  logic [CODE_W-1:0] cur_code,
  output logic [CODE_W-1:0] target,
  output logic              hold
);

  always_comb begin
    target = '0;
    for (int i = 0; i < N_STEPS; i++) begin
      target = target + CODE_W'(peak_flags[i]);
    end
  end

  // Step c is kept while the flag one level below its attack level is set.
  always_comb begin
    hold = 1'b0;
    for (int c = 1; c <= N_STEPS; c++) begin
      if (cur_code == CODE_W'(c)) hold = peak_flags[N_STEPS + 1 - c];
    end
  end

endmodule

// File: rtl/gr_step_reg.sv
module gr_step_reg #(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] target,
  input  logic              hold,
  output logic [CODE_W-1:0] code_q
);
  import gr_pkg::*;

  logic [CODE_W-1:0] code_d;

  assign code_d = CODE_W'(gr_next_code(8'(code_q), 8'(target), hold));

  always_ff @(posedge clk) begin
    if (rst) code_q <= '0;
    else     code_q <= code_d;
  end

endmodule

// File: rtl/gr_atten_ctrl.sv
module gr_atten_ctrl #(
  parameter int SAMPLE_W = 12,
  parameter int N_STEPS  = 5
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic signed [SAMPLE_W-1:0] sample,
  output logic [2:0]                 att_code
);

  localparam int CODE_W = $clog2(N_STEPS + 1);
  localparam int LEVELS = N_STEPS + 1;

  logic [LEVELS-1:0] peak_flags;
  logic [CODE_W-1:0] step_target;
  logic              step_hold;
  logic [CODE_W-1:0] code_q;

  gr_peak_latch #(.SAMPLE_W(SAMPLE_W), .LEVELS(LEVELS)) u_latch (
    .clk    (clk),
    .rst    (rst),
    .sample (sample),
    .peak_q (peak_flags)
  );

  gr_level_encode #(.N_STEPS(N_STEPS), .CODE_W(CODE_W)) u_enc (
    .peak_flags (peak_flags),
    .cur_code   (code_q),
    .target     (step_target),
    .hold       (step_hold)
  );

  gr_step_reg #(.CODE_W(CODE_W)) u_step (
    .clk    (clk),
    .rst    (rst),
    .target (step_target),
    .hold   (step_hold),
    .code_q (code_q)
  );

  assign att_code = 3'(code_q);

endmodule

// File: rtl/gr_atten_ctrl_chk.sv
module gr_atten_ctrl_chk #(
  parameter int N_STEPS = 5,
  parameter int CODE_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        att_code,
  input logic [N_STEPS:0]  peak_flags,
  input logic [CODE_W-1:0] step_target
);

  logic [N_STEPS:0] gap;
  int               n_seen;

  assign gap    = (peak_flags << 1) & ~peak_flags;
  assign n_seen = $countones(peak_flags[N_STEPS-1:0]);

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (att_code == 3'd0 && peak_flags == '0)); // R1

  AST_FLAGS_THERMO: assert property (@(posedge clk) disable iff (rst)
    gap == '0); // R2

  AST_RISE_JUMP: assert property (@(posedge clk) disable iff (rst)
    (n_seen > int'(att_code)) |=> (int'(att_code) == $past(n_seen))); // R5

  AST_RELEASE_BOUND: assert property (@(posedge clk) disable iff (rst)
    (n_seen < int'(att_code)) |=>
      (int'(att_code) == $past(n_seen) || att_code == $past(att_code))); // R7

  AST_CODE_CAP: assert property (@(posedge clk) disable iff (rst)
    int'(att_code) <= N_STEPS); // R8

  AST_TARGET_CAP: assert property (@(posedge clk) disable iff (rst)
    int'(step_target) <= N_STEPS); // R8

endmodule

bind gr_atten_ctrl gr_atten_ctrl_chk #(.N_STEPS(N_STEPS), .CODE_W(CODE_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .att_code    (att_code),
  .peak_flags  (peak_flags),
  .step_target (step_target)
);

// File: tb/tb_gr_atten_ctrl.sv
module tb_gr_atten_ctrl;

  localparam int W = 12;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic signed [W-1:0] sample = '0;
  logic [2:0]         att_code;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  gr_atten_ctrl #(.SAMPLE_W(W), .N_STEPS(5)) dut (
    .clk      (clk),
    .rst      (rst),
    .sample   (sample),
    .att_code (att_code)
  );

  // FS = 2048; attack levels 1024, 512, 256, 128, 64; lowest hold level 32.
  localparam int VN = 17;
  localparam int VX [VN] = '{
    0,      // R1 quiet stays 0
    40,     // R2 below FS/32
    64,     // R2 exactly FS/32 -> 1
    63,     // R6 inside band of step 1
    31,     // R7 below FS/64 -> 0
    -1024,  // R3 R5 negative, jump to 5
    2047,   // R8 saturate
    -2048,  // R3 R8 most negative
    600,    // R6 n=4, hold 5 (>=512)
    511,    // R7 drop to 3
    -300,   // R6 stays 3
    -200,   // R6 n=2, hold 3 (>=128)
    -127,   // R7 n=1, drop to 1
    130,    // R5 rise one step to 2
    -40,    // R7 drop two steps to 0
    -1023,  // R5 jump to 4
    0       // R7 full flush
  };
  localparam int VC [VN] = '{0, 0, 1, 1, 0, 5, 5, 5, 5, 3, 3, 3, 1, 2, 0, 4, 0};

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: att_code actual %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic edges(input int k);
    for (int i = 0; i < k; i++) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    sample = 12'sd2047;
    edges(3);
    check("R1 code held in reset", int'(att_code), 0);
    rst = 1'b0;
    sample = '0;
    edges(3);
    check("R1 code after reset release", int'(att_code), 0);

    // Table walk: each sample is held for three edges.
    for (int i = 0; i < VN; i++) begin
      sample = W'(VX[i]);
      edges(3);
      check($sformatf("table(R2,R3,R5,R6,R7,R8) row %0d", i), int'(att_code), VC[i]);
    end

    // R4 latency and R7 one-sample flush from code 0.
    sample = 12'sd1024;
    edges(1);
    check("R4 unchanged after one edge", int'(att_code), 0);
    sample = '0;
    edges(1);
    check("R4 code after two edges", int'(att_code), 5);
    edges(1);
    check("R7 one quiet sample flushes", int'(att_code), 0);

    // R5 rise from a non-zero step.
    sample = 12'sd128;
    edges(3);
    check("R5 settle at step 2", int'(att_code), 2);
    sample = -12'sd700;
    edges(2);
    check("R5 jump 2 to 4", int'(att_code), 4);

    // R1 reset in mid-run clears code and captured flags.
    sample = 12'sd1500;
    edges(2);
    check("R8 large sample step 5", int'(att_code), 5);
    rst = 1'b1;
    edges(1);
    check("R1 reset clears code at first edge", int'(att_code), 0);
    edges(1);
    check("R1 sample ignored under reset", int'(att_code), 0);
    sample = '0;
    rst = 1'b0;
    edges(2);
    check("R1 flags cleared by reset", int'(att_code), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule